// File: doc/BRIEF.md
# Command-Controlled Serial Receiver with Three-Deep Holding Queue

This block receives asynchronous serial characters on a single input line and hands them to a processor through a small queue. The line is resynchronised to the system clock and examined on every pulse of a 16x oversampling tick. A start bit is confirmed at the middle of its bit time. The eight data bits are then collected least significant bit first into a shift stage. A completed character moves into a three-entry first-in first-out holding queue. The processor pulls the oldest character out with a read strobe. The character appears on a registered data output in the following cycle.

Whether the receiver listens at all is set by a two-bit command applied with a one-cycle strobe. Enabling restarts the receiver in the hunt for a start bit. Disabling stops it at once and throws away a partly received character, but leaves the queue untouched. Two mode inputs, one for an addressed multi-station link and one for internal loop-back, keep the receiver running whatever the enable state is. The multi-station mode also blocks the enable command.

Top module: `rxq_receiver`

## Requirements
- R1: After reset, `rd_data` is 8'hFF, `data_avail` and `overrun` are 0, and the receiver is disabled: a frame sent before any command is not queued.
- R2: A character is framed as a low start bit, 8 data bits least significant bit first, and a high stop bit. Each bit lasts 16 ticks. When enabled, every correctly framed character is queued intact.
- R3: A start bit is accepted only if the line is still low at the tick 8 ticks after the falling edge was seen. A shorter low pulse queues nothing.
- R4: A read strobe while `data_avail` is 1 removes the oldest queued character, and `rd_data` shows it one cycle later. Characters leave in arrival order. A read strobe while the queue is empty leaves `rd_data` and the queue unchanged.
- R5: The queue holds 3 characters. A character completing while the queue is full, with no read in the same cycle, is discarded and sets `overrun`. `overrun` stays set until reset, and the queued characters are not disturbed.
- R6: A read in the same cycle as a character completion performs both operations, so a full queue accepts the new character and keeps 3 entries.
- R7: Command code 2'b01 enables the receiver and restarts it in the search for a start bit. It has no effect while already enabled, and a frame in progress is then not disturbed. It is ignored while `mode_multidrop` is 1.
- R8: Command code 2'b10 disables the receiver at once and discards a partly received character. Queued characters and `overrun` are not changed.
- R9: While `mode_loopback` or `mode_multidrop` is 1, the receiver keeps receiving regardless of the enable state. A disable command given during a frame in those modes does not discard that frame.
- R10: Command codes 2'b00 and 2'b11 leave the receiver state unchanged. A code applied with `cmd_valid` at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_strobe | input | 1 | Processor read request, pops the oldest character |
| rd_data | output | 8 | Registered character from the latest read |
| data_avail | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky flag: a character was lost to a full queue |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_code` |
| cmd_code | input | 2 | 00 none, 01 enable, 10 disable, 11 reserved (none) |
| mode_multidrop | input | 1 | Multi-station mode: receiver always runs, enable ignored |
| mode_loopback | input | 1 | Loop-back mode: receiver always runs |

## Verification
A bit counter or phase counter that has slipped shows up as a wrong byte or a missing character at the read port within one frame, about 160 ticks. A queue pointer or occupancy error shows up as wrong ordering, a stale `rd_data`, or a `data_avail` that does not match the number of characters sent, on the next read. A wrong enable state is exposed only by sending a complete frame and watching whether `data_avail` rises. For that reason every command check is followed by a full frame and the queue is inspected afterwards.

// File: rtl/rxq_pkg.sv
// Package: shared constants and encodings for the serial receiver.
// Assumes: command codes are decoded by rxq_ctl only.
package rxq_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_RSVD    = 2'b11
    } rx_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_START = 2'b01,
        ST_DATA  = 2'b10,
        ST_STOP  = 2'b11
    } rx_state_e;

endpackage

// File: rtl/rxq_sync.sv
// Module: rxq_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. Assumes STAGES >= 2. Resets to the idle (high) level.
module rxq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the line level through the synchronising chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxq_deser.sv
// Module: rxq_deser
// Character assembler. It hunts for a falling edge, confirms the start bit
// at half a bit time, then samples DATA_W data bits (LSB first) and the
// stop bit once per OSR ticks. It emits a one-cycle push with the
// character. Assumes 'tick' is a one-cycle pulse and 'rx' is synchronous.
// 'run' low or 'flush' high returns it to the hunt state at once.
module rxq_deser
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              run,
    input  logic              flush,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              busy
);

    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  phase;
    logic [BIT_W-1:0]  nbit;
    logic [DATA_W-1:0] shreg;

    // Frame state machine: hunt, confirm start, shift data, take stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || flush) begin
            state <= ST_IDLE;
            phase <= '0;
            nbit  <= '0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!rx) begin
                            state <= ST_START;
                            phase <= '0;
                        end
                    end
                    ST_START: begin
                        if (phase == HALF_LAST) begin
                            phase <= '0;
                            nbit  <= '0;
                            state <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (phase == FULL_LAST) begin
                            phase <= '0;
                            if (nbit == BIT_LAST) state <= ST_STOP;
                            else                  nbit  <= nbit + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (phase == FULL_LAST) begin
                            push  <= 1'b1;
                            state <= ST_IDLE;
                            phase <= '0;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Shift data bits in from the top so the first bit lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (run && !flush && tick && state == ST_DATA && phase == FULL_LAST) begin
            shreg <= {rx, shreg[DATA_W-1:1]};
        end
    end

    // Hold the finished character alongside the push pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_data <= '0;
        end else if (run && !flush && tick && state == ST_STOP && phase == FULL_LAST) begin
            push_data <= shreg;
        end
    end

    assign busy = (state != ST_IDLE);

    // R2: a push is always followed by a return to the hunt state
    assert_push_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> state == ST_IDLE);

    // R3: leaving the start state into data only happens on a tick
    assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && !tick) |=> state != ST_DATA);

endmodule

// File: rtl/rxq_fifo.sv
// Module: rxq_fifo
// Shift-style holding queue of DEPTH entries. Entry 0 is always the oldest.
// A pop copies entry 0 to the registered output. A push that finds no room
// (full and no pop) is dropped and sets a sticky overrun flag.
// Assumes push is a single-cycle pulse.
module rxq_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              overrun
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  count;
    logic              pop;
    logic              accept;
    logic [CNT_W-1:0]  wr_idx;

    assign pop    = rd && (count != '0);
    assign accept = push && ((count != FULL_CNT) || pop);
    assign wr_idx = pop ? (count - 1'b1) : count;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            if (gi == DEPTH - 1) begin : g_last
                // Last slot: written by a push, otherwise kept.
                always_ff @(posedge clk) begin
                    if (!rst_n)                                    slot[gi] <= '0;
                    else if (accept && wr_idx == CNT_W'(gi))       slot[gi] <= push_data;
                end
            end else begin : g_mid
                // Inner slot: written by a push, else shifts toward the head on pop.
                always_ff @(posedge clk) begin
                    if (!rst_n)                                    slot[gi] <= '0;
                    else if (accept && wr_idx == CNT_W'(gi))       slot[gi] <= push_data;
                    else if (pop)                                  slot[gi] <= slot[gi+1];
                end
            end
        end
    endgenerate

    // Track the occupancy from accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(accept) - CNT_W'(pop);
    end

    // Present the head character on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_data <= '1;
        else if (pop) rd_data <= slot[0];
    end

    // Latch any lost character until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               overrun <= 1'b0;
        else if (push && !accept) overrun <= 1'b1;
    end

    assign not_empty = (count != '0);

    // R5: occupancy never exceeds the depth
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R5: overrun is sticky
    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5: a push into a full queue without a read loses it and flags it
    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == FULL_CNT && !rd) |=> (overrun && count == FULL_CNT));

    // R6: push and pop in one cycle keep the occupancy
    assert_pop_push_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd && count != '0) |=> count == $past(count));

    // R4: a lone pop lowers the occupancy by one
    assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !push && count != '0) |=> count == $past(count) - 1'b1);

    // R4: reading an empty queue leaves the output register alone
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && count == '0) |=> $stable(rd_data));

endmodule

// File: rtl/rxq_ctl.sv
// Module: rxq_ctl
// Command decoder and enable state. It produces 'run' (receiver active) and
// 'flush' (abort the character in progress). Loop-back or multidrop mode
// forces 'run' high. Multidrop blocks the enable command. Reserved and
// no-action codes change nothing.
module rxq_ctl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       mode_multidrop,
    input  logic       mode_loopback,
    output logic       run,
    output logic       flush
);

    logic enabled;
    logic forced;
    logic do_enable;
    logic do_disable;

    assign forced     = mode_multidrop || mode_loopback;
    assign do_enable  = cmd_valid && (cmd_code == CMD_ENABLE) && !mode_multidrop && !enabled;
    assign do_disable = cmd_valid && (cmd_code == CMD_DISABLE);

    // Hold the enable state, changed only by the two active commands.
    always_ff @(posedge clk) begin
        if (!rst_n)          enabled <= 1'b0;
        else if (do_enable)  enabled <= 1'b1;
        else if (do_disable) enabled <= 1'b0;
    end

    // Abort the assembler on a fresh enable, or on a disable not overridden by a mode.
    assign flush = do_enable || (do_disable && !forced);
    assign run   = enabled || forced;

    // R7: enable is refused while multidrop mode holds
    assert_md_blocks_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_ENABLE && mode_multidrop && !enabled) |=> !enabled);

    // R8: a disable command always clears the enable state
    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_DISABLE) |=> !enabled);

    // R10: without a strobe, or with codes 00/11, the enable state holds
    assert_idle_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_code == CMD_NONE || cmd_code == CMD_RSVD) |=> $stable(enabled));

endmodule

// File: rtl/rxq_receiver.sv
// Module: rxq_receiver (top)
// Serial receiver: synchroniser, character assembler, command control and
// a DEPTH-entry holding queue read by the processor.
// Assumes os_tick is a one-cycle pulse at OSR times the bit rate.
module rxq_receiver #(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 3,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_serial,
    input  logic              os_tick,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_avail,
    output logic              overrun,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    input  logic              mode_multidrop,
    input  logic              mode_loopback
);

    logic              rx_sync;
    logic              run;
    logic              flush;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              busy;

    rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (rx_sync)
    );

    rxq_ctl u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_code       (cmd_code),
        .mode_multidrop (mode_multidrop),
        .mode_loopback  (mode_loopback),
        .run            (run),
        .flush          (flush)
    );

    rxq_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rx        (rx_sync),
        .run       (run),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .busy      (busy)
    );

    rxq_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .rd        (rd_strobe),
        .rd_data   (rd_data),
        .not_empty (data_avail),
        .overrun   (overrun)
    );

    // R8: an unoverridden disable leaves the assembler idle in the next cycle
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 2'b10 && !mode_loopback && !mode_multidrop) |=> !busy);

    // R7: a fresh enable restarts the hunt for a start bit
    assert_flush_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy);

endmodule

// File: tb/tb_rxq_receiver.sv
// Scoreboard bench: send_frame pushes expected characters into exp_q, and
// the monitor (or read_one) pops and compares what the design delivers.
module tb_rxq_receiver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_serial = 1'b1;
    logic       os_tick = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       data_avail;
    logic       overrun;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'b00;
    logic       mode_multidrop = 1'b0;
    logic       mode_loopback = 1'b0;

    int checks = 0;
    int errors = 0;
    bit auto_read = 1'b0;
    logic [7:0] exp_q [$];

    rxq_receiver dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_serial      (rx_serial),
        .os_tick        (os_tick),
        .rd_strobe      (rd_strobe),
        .rd_data        (rd_data),
        .data_avail     (data_avail),
        .overrun        (overrun),
        .cmd_valid      (cmd_valid),
        .cmd_code       (cmd_code),
        .mode_multidrop (mode_multidrop),
        .mode_loopback  (mode_loopback)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Oversampling tick: one cycle in four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(posedge clk); while (!os_tick);
        end
    endtask

    task automatic pulse_cmd(input logic [1:0] c);
        #1 cmd_valid = 1'b1; cmd_code = c;
        @(posedge clk);
        #1 cmd_valid = 1'b0; cmd_code = 2'b00;
    endtask

    task automatic compare_head(input string req);
        logic [7:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, req, rd_data, 32'hDEAD);
        end else begin
            e = exp_q.pop_front();
            check(rd_data == e, req, rd_data, e);
        end
    endtask

    // Drive one frame; optionally issue a command before data bit cut_bit,
    // or pop in the exact cycle the character is pushed.
    task automatic send_frame(input logic [7:0] b, input int cut_bit,
                              input logic [1:0] cut_cmd, input bit pop_at_push);
        wait_ticks(1);
        #1 rx_serial = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            if (i == cut_bit) pulse_cmd(cut_cmd);
            #1 rx_serial = b[i];
            wait_ticks(16);
        end
        #1 rx_serial = 1'b1;
        if (pop_at_push) begin
            wait_ticks(9);
            #1 rd_strobe = 1'b1;
            @(posedge clk);
            #1 rd_strobe = 1'b0;
            @(negedge clk);
            compare_head("R6 read in push cycle");
            wait_ticks(7);
        end else begin
            wait_ticks(16);
        end
        wait_ticks(2);
    endtask

    task automatic send_exp(input logic [7:0] b);
        exp_q.push_back(b);
        send_frame(b, -1, 2'b00, 1'b0);
    endtask

    task automatic read_one(input string req);
        @(negedge clk);
        check(data_avail == 1'b1, req, data_avail, 1);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        compare_head(req);
    endtask

    // Monitor: pops the queue whenever auto_read is on.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && data_avail) begin
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
                compare_head("R2 received character");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_data == 8'hFF, "R1 rd_data reset", rd_data, 8'hFF);
        check(data_avail == 1'b0, "R1 data_avail reset", data_avail, 0);
        check(overrun == 1'b0, "R1 overrun reset", overrun, 0);
        send_frame(8'h81, -1, 2'b00, 1'b0);
        @(negedge clk);
        check(data_avail == 1'b0, "R1 disabled after reset", data_avail, 0);

        // R2: several patterns, read by the monitor
        pulse_cmd(2'b01);
        auto_read = 1'b1;
        send_exp(8'hA5);
        send_exp(8'h3C);
        send_exp(8'h00);
        send_exp(8'hFF);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 all characters delivered", exp_q.size(), 0);

        // R3: short low pulse rejected
        auto_read = 1'b0;
        wait_ticks(1);
        #1 rx_serial = 1'b0;
        wait_ticks(4);
        #1 rx_serial = 1'b1;
        wait_ticks(30);
        @(negedge clk);
        check(data_avail == 1'b0, "R3 glitch not queued", data_avail, 0);
        auto_read = 1'b1;
        send_exp(8'h5A);
        repeat (10) @(negedge clk);
        auto_read = 1'b0;
        check(exp_q.size() == 0, "R3 frame after glitch", exp_q.size(), 0);

        // R4: read from empty queue changes nothing
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h5A, "R4 empty read keeps rd_data", rd_data, 8'h5A);
        check(data_avail == 1'b0, "R4 empty read keeps queue", data_avail, 0);

        // R10: codes 11 and 00, and an unstrobed disable, do nothing
        pulse_cmd(2'b11);
        pulse_cmd(2'b00);
        #1 cmd_code = 2'b10;
        repeat (3) @(posedge clk);
        #1 cmd_code = 2'b00;
        send_exp(8'hC3);
        read_one("R10 receiver still enabled");

        // R4: arrival order
        send_exp(8'h01);
        send_exp(8'h02);
        read_one("R4 oldest first");
        read_one("R4 second");

        // R5: fourth character into a full queue is lost
        send_exp(8'h10);
        send_exp(8'h20);
        send_exp(8'h30);
        check(overrun == 1'b0, "R5 no overrun at three", overrun, 0);
        send_frame(8'h40, -1, 2'b00, 1'b0);
        @(negedge clk);
        check(overrun == 1'b1, "R5 overrun set", overrun, 1);
        read_one("R5 first kept");
        read_one("R5 second kept");
        read_one("R5 third kept");
        @(negedge clk);
        check(data_avail == 1'b0, "R5 lost character absent", data_avail, 0);
        check(overrun == 1'b1, "R5 overrun sticky", overrun, 1);

        // R6: pop and push in the same cycle on a full queue
        send_exp(8'h61);
        send_exp(8'h62);
        send_exp(8'h63);
        exp_q.push_back(8'h64);
        send_frame(8'h64, -1, 2'b00, 1'b1);
        read_one("R6 entry two");
        read_one("R6 entry three");
        read_one("R6 accepted character");
        @(negedge clk);
        check(data_avail == 1'b0, "R6 queue drained", data_avail, 0);

        // R8: disable mid-frame drops the partial character only
        send_exp(8'h11);
        send_frame(8'h77, 3, 2'b10, 1'b0);
        @(negedge clk);
        check(overrun == 1'b1, "R8 overrun untouched", overrun, 1);
        read_one("R8 queued character kept");
        @(negedge clk);
        check(data_avail == 1'b0, "R8 partial character dropped", data_avail, 0);
        send_frame(8'h22, -1, 2'b00, 1'b0);
        @(negedge clk);
        check(data_avail == 1'b0, "R8 disabled receiver ignores line", data_avail, 0);

        // R7: enable, repeated enable mid-frame is harmless, blocked in multidrop
        pulse_cmd(2'b01);
        exp_q.push_back(8'h33);
        send_frame(8'h33, 4, 2'b01, 1'b0);
        read_one("R7 enable while enabled");
        pulse_cmd(2'b10);
        mode_multidrop = 1'b1;
        pulse_cmd(2'b01);
        mode_multidrop = 1'b0;
        send_frame(8'h44, -1, 2'b00, 1'b0);
        @(negedge clk);
        check(data_avail == 1'b0, "R7 enable ignored in multidrop", data_avail, 0);

        // R9: modes keep the receiver running
        mode_loopback = 1'b1;
        exp_q.push_back(8'h55);
        send_frame(8'h55, 2, 2'b10, 1'b0);
        read_one("R9 loop-back overrides disable");
        mode_loopback = 1'b0;
        mode_multidrop = 1'b1;
        send_exp(8'h66);
        read_one("R9 multidrop keeps receiving");
        mode_multidrop = 1'b0;
        send_frame(8'h99, -1, 2'b00, 1'b0);
        @(negedge clk);
        check(data_avail == 1'b0, "R9 disabled once modes clear", data_avail, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule